// File: doc/BRIEF.md
# Link Configuration Fallback Selector

This block walks an ordered list of display link configurations during link bring-up and hands the training logic one candidate at a time. Every candidate is a lane count paired with a per-lane bandwidth code. From these the block also produces the per-lane bandwidth (code × 27000) and the total link rate. Candidates that the attached sink cannot carry are passed over. Before any comparison, the sink's lane and rate limits are first cut down to what the local encoder supports.

A `start` pulse captures the limits and an optional required payload rate. The walk then begins, either at the top of the list or at the lowest-rate candidate that still carries the payload once 8b/10b overhead is counted. When the walk reaches a fitting candidate, the block raises `cfg_valid` and holds it there. A `train_fail` pulse moves the walk to the next fitting candidate. A `train_pass` pulse ends the walk with success. Running past the last candidate ends the walk with an exhausted status.

Top module: `link_fallback_sel`

## Requirements
- R1: After reset, `cfg_valid`, `done_ok` and `done_fail` are 0, and the config outputs read 0.
- R2: The list, by index, holds these (lanes, code, total rate) candidates: 0:(4,0x14,2160000) 1:(4,0x0a,1080000) 2:(2,0x14,1080000) 3:(4,0x06,648000) 4:(2,0x0a,540000) 5:(1,0x14,540000) 6:(2,0x06,324000) 7:(1,0x0a,270000) 8:(1,0x06,162000). Index 9 is the end of the list.
- R3: A candidate is skipped when its lane count is above the effective lane limit or its code is above the effective code limit.
- R4: At `start`, the effective lane limit becomes min(`sink_max_lanes`, `enc_max_lanes`) and the effective code limit becomes min(`sink_max_code`, `enc_max_code`).
- R5: With `req_rate` = 0 the walk begins at index 0. Otherwise need = floor(`req_rate`/8)×10, and the walk begins at index s. Here s is the largest value such that every index 1..s has a total rate ≥ need, or 0 if index 1 falls short.
- R6: While a candidate is shown, `cfg_lanes` is its lane count, `cfg_code` is its code, `cfg_lane_bw` = code×27000, `cfg_rate` is its total rate, and `cfg_index` is its index.
- R7: While `cfg_valid` is high, `train_fail` moves to the next fitting candidate at a higher index. `train_pass` (which wins if both are high) sets `done_ok` and keeps the candidate shown.
- R8: When the walk reaches index 9, `done_fail` goes high and `cfg_valid` stays low.
- R9: The walk inspects one index per clock. The result appears 1+k clocks after the edge that samples `start` or `train_fail`, where k is the number of indices skipped.
- R10: `train_fail` and `train_pass` have no effect unless `cfg_valid` is high. Both done states hold until the next `start`, and `start` restarts the walk from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new walk, capturing limits and required rate |
| train_fail | input | 1 | Training failed on the shown candidate |
| train_pass | input | 1 | Training succeeded on the shown candidate |
| sink_max_lanes | input | LANE_W | Sink lane limit |
| sink_max_code | input | CODE_W | Sink bandwidth code limit |
| enc_max_lanes | input | LANE_W | Encoder lane limit |
| enc_max_code | input | CODE_W | Encoder bandwidth code limit |
| req_rate | input | RATE_W | Required payload rate, 0 for none |
| cfg_valid | output | 1 | A candidate is offered for training |
| cfg_index | output | IDX_W | Index of the shown candidate |
| cfg_lanes | output | LANE_W | Lane count of the shown candidate |
| cfg_code | output | CODE_W | Bandwidth code of the shown candidate |
| cfg_lane_bw | output | RATE_W | Per-lane bandwidth, code × 27000 |
| cfg_rate | output | RATE_W | Total rate of the shown candidate |
| done_ok | output | 1 | Walk ended with a trained candidate |
| done_fail | output | 1 | Walk ran off the end of the list |

## Verification
The bench goes after limits that exclude long runs of candidates, including a case where the encoder rather than the sink sets the limit. A design that compared against the raw sink value would offer lane counts the encoder cannot drive, and a design that skipped several indices in one clock would show up with the wrong latency. Required-rate cases sit just above, well above and below the list rates, and include a rate small enough that the converted need is zero. A wrong start index would offer a faster or slower link than asked for. The bench also fails past the last fitting candidate, sends pulses in done states, and restarts mid-walk. A design that wrapped around, or reacted to stray pulses, would show a candidate after the walk should have ended.

// File: rtl/lfs_pkg.sv
package lfs_pkg;

   localparam int TABLE_LEN = 9;
   localparam int LANE_UNIT_BW = 27000;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEARCH,
      ST_PRESENT,
      ST_PASS,
      ST_EXHAUST
   } lfs_state_e;

   // Lane count per candidate, descending total rate order.
   function automatic logic [31:0] tbl_lanes(input int i);
      case (i)
         0, 1, 3:    return 32'd4;
         2, 4, 6:    return 32'd2;
         5, 7, 8:    return 32'd1;
         default:    return 32'd0;
      endcase
   endfunction

   // Per-lane bandwidth code per candidate.
   function automatic logic [31:0] tbl_code(input int i);
      case (i)
         0, 2, 5:    return 32'h14;
         1, 4, 7:    return 32'h0a;
         3, 6, 8:    return 32'h06;
         default:    return 32'h00;
      endcase
   endfunction

   // Total rate is lanes times code times the unit bandwidth.
   function automatic logic [31:0] tbl_rate(input int i);
      return tbl_lanes(i) * tbl_code(i) * 32'(LANE_UNIT_BW);
   endfunction

endpackage

// File: rtl/lfs_clamp.sv
module lfs_clamp #(
   parameter int W = 8
) (
   input  logic [W-1:0] lim_a,
   input  logic [W-1:0] lim_b,
   output logic [W-1:0] lim_min
);
   assign lim_min = (lim_a < lim_b) ? lim_a : lim_b;
endmodule

// File: rtl/lfs_fit_mask.sv
module lfs_fit_mask #(
   parameter int LANE_W = 5,
   parameter int CODE_W = 8,
   parameter int N      = lfs_pkg::TABLE_LEN,
   parameter int FIT_W  = 16
) (
   input  logic [LANE_W-1:0] eff_lanes,
   input  logic [CODE_W-1:0] eff_code,
   output logic [FIT_W-1:0]  fit
);
   for (genvar i = 0; i < FIT_W; i++) begin : g_fit
      if (i < N) begin : g_entry
         assign fit[i] = (lfs_pkg::tbl_lanes(i) <= 32'(eff_lanes)) &&
                         (lfs_pkg::tbl_code(i)  <= 32'(eff_code));
      end else begin : g_end
         // End of list and beyond always stop the walk.
         assign fit[i] = 1'b1;
      end
   end
endmodule

// File: rtl/lfs_start_pick.sv
module lfs_start_pick #(
   parameter int RATE_W       = 32,
   parameter int N            = lfs_pkg::TABLE_LEN,
   parameter int IDX_W        = 4,
   parameter bit USE_MIN_RATE = 1'b1
) (
   input  logic [RATE_W-1:0] req_rate,
   output logic [IDX_W-1:0]  start_idx
);
   localparam int NEED_W = RATE_W + 4;

   if (USE_MIN_RATE) begin : g_min_rate
      logic [NEED_W-1:0] need;
      logic [N-1:0]      meets;

      // Payload rate widened by the 8b/10b line code.
      assign need = NEED_W'(req_rate >> 3) * NEED_W'(10);

      for (genvar j = 0; j < N; j++) begin : g_meet
         assign meets[j] = (NEED_W'(lfs_pkg::tbl_rate(j)) >= need);
      end

      always_comb begin
         logic run;
         start_idx = '0;
         run       = 1'b1;
         if (req_rate != '0) begin
            for (int j = 1; j < N; j++) begin
               if (run && meets[j]) start_idx = IDX_W'(j);
               else                 run = 1'b0;
            end
         end
      end
   end else begin : g_top_only
      logic unused_req;
      assign unused_req = ^req_rate;
      assign start_idx  = '0;
   end
endmodule

// File: rtl/link_fallback_sel.sv
module link_fallback_sel #(
   parameter int LANE_W       = 5,
   parameter int CODE_W       = 8,
   parameter int RATE_W       = 32,
   parameter bit USE_MIN_RATE = 1'b1,
   parameter int N            = lfs_pkg::TABLE_LEN,
   parameter int IDX_W        = $clog2(N + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              train_fail,
   input  logic              train_pass,
   input  logic [LANE_W-1:0] sink_max_lanes,
   input  logic [CODE_W-1:0] sink_max_code,
   input  logic [LANE_W-1:0] enc_max_lanes,
   input  logic [CODE_W-1:0] enc_max_code,
   input  logic [RATE_W-1:0] req_rate,
   output logic              cfg_valid,
   output logic [IDX_W-1:0]  cfg_index,
   output logic [LANE_W-1:0] cfg_lanes,
   output logic [CODE_W-1:0] cfg_code,
   output logic [RATE_W-1:0] cfg_lane_bw,
   output logic [RATE_W-1:0] cfg_rate,
   output logic              done_ok,
   output logic              done_fail
);
   import lfs_pkg::*;

   localparam int FIT_W = 1 << IDX_W;
   localparam int CNT_W = IDX_W + 1;

   // Elaboration checks on parameter choices.
   if (LANE_W < 3) begin : g_chk_lane
      $error("LANE_W too small for a lane count of 4");
   end
   if (CODE_W < 5) begin : g_chk_code
      $error("CODE_W too small for code 0x14");
   end
   if (RATE_W < 22) begin : g_chk_rate
      $error("RATE_W too small for the highest total rate");
   end
   if (N != TABLE_LEN) begin : g_chk_len
      $error("N must equal the candidate list length");
   end

   lfs_state_e        state;
   logic [IDX_W-1:0]  idx;
   logic [LANE_W-1:0] lim_lanes, clamp_lanes;
   logic [CODE_W-1:0] lim_code, clamp_code;
   logic [IDX_W-1:0]  start_idx;
   logic [FIT_W-1:0]  fit;
   logic [CNT_W-1:0]  srch_cnt;
   logic              at_end, show;

   lfs_clamp #(.W(LANE_W)) u_clamp_lanes (
      .lim_a   (sink_max_lanes),
      .lim_b   (enc_max_lanes),
      .lim_min (clamp_lanes)
   );

   lfs_clamp #(.W(CODE_W)) u_clamp_code (
      .lim_a   (sink_max_code),
      .lim_b   (enc_max_code),
      .lim_min (clamp_code)
   );

   lfs_start_pick #(
      .RATE_W       (RATE_W),
      .N            (N),
      .IDX_W        (IDX_W),
      .USE_MIN_RATE (USE_MIN_RATE)
   ) u_start (
      .req_rate  (req_rate),
      .start_idx (start_idx)
   );

   lfs_fit_mask #(
      .LANE_W (LANE_W),
      .CODE_W (CODE_W),
      .N      (N),
      .FIT_W  (FIT_W)
   ) u_fit (
      .eff_lanes (lim_lanes),
      .eff_code  (lim_code),
      .fit       (fit)
   );

   assign at_end = (idx >= IDX_W'(N));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         idx       <= '0;
         lim_lanes <= '0;
         lim_code  <= '0;
      end else if (start) begin
         state     <= ST_SEARCH;
         idx       <= start_idx;
         lim_lanes <= clamp_lanes;
         lim_code  <= clamp_code;
      end else begin
         case (state)
            ST_SEARCH: begin
               if (at_end)        state <= ST_EXHAUST;
               else if (fit[idx]) state <= ST_PRESENT;
               else               idx   <= idx + IDX_W'(1);
            end
            ST_PRESENT: begin
               if (train_pass) begin
                  state <= ST_PASS;
               end else if (train_fail) begin
                  state <= ST_SEARCH;
                  idx   <= idx + IDX_W'(1);
               end
            end
            default: ;
         endcase
      end
   end

   // Cycles spent walking, used only by the latency bound check.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    srch_cnt <= '0;
      else if (state == ST_SEARCH)   srch_cnt <= srch_cnt + CNT_W'(1);
      else                           srch_cnt <= '0;
   end

   assign show        = (state == ST_PRESENT) || (state == ST_PASS);
   assign cfg_valid   = (state == ST_PRESENT);
   assign done_ok     = (state == ST_PASS);
   assign done_fail   = (state == ST_EXHAUST);
   assign cfg_index   = show ? idx : '0;
   assign cfg_lanes   = show ? LANE_W'(tbl_lanes(int'(idx))) : '0;
   assign cfg_code    = show ? CODE_W'(tbl_code(int'(idx)))  : '0;
   assign cfg_lane_bw = show ? RATE_W'(tbl_code(int'(idx)) * 32'(LANE_UNIT_BW)) : '0;
   assign cfg_rate    = show ? RATE_W'(tbl_rate(int'(idx))) : '0;

   // An offered candidate respects the limits captured at start.
   assert_valid_fits_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid |-> (cfg_lanes <= lim_lanes) && (cfg_code <= lim_code));

   // A failure moves away from the shown candidate.
   assert_fail_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_valid && train_fail && !train_pass && !start) |=> !cfg_valid);

   // A pass freezes the shown candidate.
   assert_pass_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_valid && train_pass && !start) |=> (done_ok && $stable(cfg_index)));

   // Terminal states never overlap with an offer.
   assert_end_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_fail && (cfg_valid || done_ok)));

   // Walk never takes more clocks than list entries plus the end.
   assert_walk_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      srch_cnt <= CNT_W'(N + 1));

   // Done states persist until a new start.
   assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((done_fail || done_ok) && !start) |=> $stable({done_fail, done_ok}));

endmodule

// File: tb/link_fallback_sel_test.sv
module link_fallback_sel_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, train_fail = 1'b0, train_pass = 1'b0;
   logic [4:0]  sink_max_lanes = '0, enc_max_lanes = '0;
   logic [7:0]  sink_max_code = '0, enc_max_code = '0;
   logic [31:0] req_rate = '0;
   logic        cfg_valid, done_ok, done_fail;
   logic [3:0]  cfg_index;
   logic [4:0]  cfg_lanes;
   logic [7:0]  cfg_code;
   logic [31:0] cfg_lane_bw, cfg_rate;

   int checks = 0, fails = 0;

   always #4 clk = ~clk;

   link_fallback_sel uut (
      .clk(clk), .rst_n(rst_n), .start(start), .train_fail(train_fail),
      .train_pass(train_pass), .sink_max_lanes(sink_max_lanes),
      .sink_max_code(sink_max_code), .enc_max_lanes(enc_max_lanes),
      .enc_max_code(enc_max_code), .req_rate(req_rate),
      .cfg_valid(cfg_valid), .cfg_index(cfg_index), .cfg_lanes(cfg_lanes),
      .cfg_code(cfg_code), .cfg_lane_bw(cfg_lane_bw), .cfg_rate(cfg_rate),
      .done_ok(done_ok), .done_fail(done_fail)
   );

   // Bench model of the candidate list from R2.
   function automatic int m_lanes(int i);
      int t[9] = '{4, 4, 2, 4, 2, 1, 2, 1, 1};
      return t[i];
   endfunction
   function automatic int m_code(int i);
      int t[9] = '{20, 10, 20, 6, 10, 20, 6, 10, 6};
      return t[i];
   endfunction
   function automatic int m_rate(int i);
      int t[9] = '{2160000, 1080000, 1080000, 648000, 540000, 540000,
                   324000, 270000, 162000};
      return t[i];
   endfunction
   function automatic int m_min(int a, int b);
      return (a < b) ? a : b;
   endfunction
   function automatic int m_start(longint req);
      longint need;
      int s;
      if (req == 0) return 0;
      need = (req / 8) * 10;
      s = 0;
      for (int j = 1; j < 9; j++) begin
         if (m_rate(j) >= need) s = j;
         else break;
      end
      return s;
   endfunction
   function automatic int m_next(int p, int el, int ec);
      int q = p;
      while (q < 9 && (m_lanes(q) > el || m_code(q) > ec)) q++;
      return q;
   endfunction

   task automatic check(string tag, string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic wait_result(output int cnt);
      cnt = 0;
      while (!cfg_valid && !done_ok && !done_fail && cnt < 30) begin
         @(negedge clk);
         cnt++;
      end
   endtask

   task automatic do_start(int sl, int sc, int el, int ec, int req, output int cnt);
      @(negedge clk);
      sink_max_lanes = 5'(sl); sink_max_code = 8'(sc);
      enc_max_lanes = 5'(el);  enc_max_code = 8'(ec);
      req_rate = 32'(req);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_result(cnt);
   endtask

   task automatic do_fail(output int cnt);
      train_fail = 1'b1;
      @(negedge clk);
      train_fail = 1'b0;
      wait_result(cnt);
   endtask

   task automatic check_entry(string tag, int q);
      check(tag, "cfg_valid", cfg_valid, 1);
      check(tag, "cfg_index", cfg_index, q);
      check("R6", "cfg_lanes", cfg_lanes, m_lanes(q));
      check("R6", "cfg_code", cfg_code, m_code(q));
      check("R6", "cfg_lane_bw", cfg_lane_bw, m_code(q) * 27000);
      check("R2", "cfg_rate", cfg_rate, m_rate(q));
   endtask

   // Walks the whole list by failing every candidate (R3 R4 R5 R7 R8 R9).
   task automatic t_walk(int sl, int sc, int el, int ec, int req);
      int cnt, p, q, elim, clim;
      elim = m_min(sl, el);
      clim = m_min(sc, ec);
      p = m_start(req);
      do_start(sl, sc, el, ec, req, cnt);
      forever begin
         q = m_next(p, elim, clim);
         check("R9", "latency", cnt, q - p + 1);
         if (q >= 9) begin
            check("R8", "done_fail", done_fail, 1);
            check("R8", "cfg_valid at end", cfg_valid, 0);
            break;
         end
         check_entry("R3", q);
         do_fail(cnt);
         p = q + 1;
      end
   endtask

   task automatic t_reset;
      check("R1", "cfg_valid", cfg_valid, 0);
      check("R1", "done_ok", done_ok, 0);
      check("R1", "done_fail", done_fail, 0);
      check("R1", "cfg_rate", cfg_rate, 0);
   endtask

   task automatic t_full_list;
      t_walk(4, 'h14, 4, 'h14, 0);
   endtask

   task automatic t_sink_narrow;
      int cnt;
      do_start(2, 'h0a, 4, 'h14, 0, cnt);
      check("R3", "skip to index 4 latency", cnt, 5);
      check_entry("R3", 4);
      do_fail(cnt);
      check("R3", "skip index 5 latency", cnt, 2);
      check_entry("R3", 6);
      t_walk(2, 'h0a, 4, 'h14, 0);
   endtask

   task automatic t_encoder_clamp;
      int cnt;
      do_start(4, 'h14, 1, 'h06, 0, cnt);
      check("R4", "latency to last", cnt, 9);
      check_entry("R4", 8);
      train_pass = 1'b1;
      @(negedge clk);
      train_pass = 1'b0;
      check("R7", "done_ok", done_ok, 1);
      check("R7", "cfg_valid after pass", cfg_valid, 0);
      check("R7", "index held", cfg_index, 8);
      train_fail = 1'b1;
      @(negedge clk);
      train_fail = 1'b0;
      @(negedge clk);
      check("R10", "done_ok after stray fail", done_ok, 1);
      check("R10", "index after stray fail", cfg_index, 8);
      t_walk(5, 'h1f, 2, 'h0a, 0);
   endtask

   task automatic t_required_rate;
      int cnt;
      do_start(4, 'h14, 4, 'h14, 800000, cnt);
      check("R5", "start index", cfg_index, 2);
      do_start(4, 'h14, 4, 'h14, 2000000, cnt);
      check("R5", "start index high need", cfg_index, 0);
      do_start(4, 'h14, 4, 'h14, 100, cnt);
      check("R5", "start index low need", cfg_index, 8);
      do_start(4, 'h14, 4, 'h14, 5, cnt);
      check("R5", "start index zero need", cfg_index, 8);
      t_walk(4, 'h14, 4, 'h14, 400000);
      t_walk(2, 'h14, 4, 'h14, 300000);
   endtask

   task automatic t_ignored_pulses;
      int cnt;
      t_walk(1, 'h06, 4, 'h14, 0);
      train_pass = 1'b1;
      @(negedge clk);
      train_pass = 1'b0;
      @(negedge clk);
      check("R10", "done_fail held", done_fail, 1);
      check("R10", "done_ok stays low", done_ok, 0);
      // Restart in the middle of a walk.
      do_start(4, 'h14, 4, 'h14, 0, cnt);
      do_fail(cnt);
      do_fail(cnt);
      check("R10", "mid-walk index", cfg_index, 2);
      do_start(4, 'h14, 4, 'h14, 0, cnt);
      check("R10", "restart index", cfg_index, 0);
      check("R10", "restart latency", cnt, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_full_list();
      t_sink_narrow();
      t_encoder_clamp();
      t_required_rate();
      t_ignored_pulses();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule